// File: doc/BRIEF.md
# Digital Video Line Capture Filter

This block sits on the receive side of a digital component video port. One element enters per pixel clock while `in_valid` is high. An element is either 10 bits wide or 8 bits wide, chosen by `cfg_wide`. The stream carries embedded timing codes. Each code is three fixed elements followed by a status word. The block finds these codes and takes the field (F), vertical blanking (V) and horizontal (H) flags from the status word. It then forwards a filtered copy of the stream toward a memory writer as a plain valid/data stream. Each forwarded element carries a start-of-line marker and the field and blanking state of its line.

`cfg_mode` selects one of three capture policies:
- Active picture only: preambles and blanking are stripped.
- Vertical blanking lines only: everything on those lines is kept, including their preambles and horizontal blanking.
- Everything: the whole stream passes unchanged.

A timing code can only be recognised once its status word has arrived. Because of this, every element is held for three accepted elements before the keep-or-drop decision is made on it. The output is therefore a lagged, in-order subset of the input.

Top module: `vid656_rx_filter`

## Requirements
- R1: A timing code is four consecutive accepted elements.
  - In 10-bit mode they are 0x3FF, 0x000, 0x000, then a status word with bit 9 = 1, F in bit 8, V in bit 7 and H in bit 6.
  - In 8-bit mode they are matched on bits 7..0 only: 0xFF, 0x00, 0x00, then a status word with bit 7 = 1, F in bit 6, V in bit 5 and H in bit 4.
  - H = 1 marks end of active video (EAV); H = 0 marks start of active video (SAV).
  - In 10-bit mode the sequence 0x0FF, 0x000, 0x000, 0x2C0 is not a timing code.
- R2: When `cfg_wide` = 0, bits 9..8 of `in_data` have no effect, and `out_data[9:8]` is 0 on every forwarded element.
- R3: Forwarded elements keep their input order. An element appears on the output, with `out_valid` high for one cycle, one cycle after the clock edge that accepts the third element following it. `out_valid` is never high in a cycle that did not follow an accepted input.
- R4: `cfg_mode` selects the policy as follows: 0 = active picture only, 1 = vertical blanking lines only, 2 or 3 = entire stream.
- R5: In mode 0, only elements between an SAV and the next EAV are forwarded, and only on lines whose latched V is 0. All four elements of every timing code are removed.
- R6: In mode 1, an element is forwarded exactly when the latched V is 1. This includes timing-code elements and horizontal blanking. V and F are latched when an SAV is detected. The elements of an SAV code already use the new V; elements from an EAV up to the next SAV keep the previous V.
- R7: In modes 2 and 3, every accepted element is forwarded.
- R8: `out_sol` is high with the first forwarded element after each SAV, and at no other time.
- R9: `out_field` and `out_vblank` give, with each forwarded element, the F and V values latched by the most recent SAV. Both are 0 before the first SAV.
- R10: Synchronous active-high reset clears `out_valid` and `out_sol`. It discards any elements held for the decision, and it sets the state to horizontal blanking with F = 0 and V = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input element present this cycle |
| in_data | input | 10 | Input element; bits 7..0 only in 8-bit mode |
| cfg_wide | input | 1 | 1 = 10-bit elements, 0 = 8-bit elements |
| cfg_mode | input | 2 | Capture policy (see R4) |
| out_valid | output | 1 | Forwarded element present |
| out_data | output | 10 | Forwarded element |
| out_sol | output | 1 | First forwarded element of a line |
| out_field | output | 1 | Field flag of the element's line |
| out_vblank | output | 1 | Vertical blanking flag of the element's line |

## Verification
A wrong latched V or a missed timing code shows up at once as extra or missing elements in the forwarded stream. The scoreboard then sees either a data mismatch on the very next output or a leftover or unexpected item at the end of the line. A stale countdown of timing-code elements leaks preamble bytes or swallows picture elements within four accepted inputs of the code. A stuck start-of-line flag marks a wrong element on the first forwarded element after an SAV.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

    localparam int ELEM_W   = 10;
    localparam int NARROW_W = 8;
    localparam int LEAD_LEN = 3;

    typedef enum logic [1:0] {
        CAP_ACTIVE   = 2'd0,
        CAP_VBLANK   = 2'd1,
        CAP_FULL     = 2'd2,
        CAP_FULL_ALT = 2'd3
    } cap_mode_e;

    typedef struct packed {
        logic field;
        logic vblank;
        logic hflag;
    } trs_flags_t;

    typedef struct packed {
        logic field;
        logic vblank;
        logic hblank;
        logic sol_pend;
    } line_state_t;

    localparam line_state_t LINE_RESET = '{field: 1'b0, vblank: 1'b0, hblank: 1'b1, sol_pend: 1'b0};

    function automatic logic [ELEM_W-1:0] norm_elem(input logic [ELEM_W-1:0] raw, input logic wide);
        return wide ? raw : {{(ELEM_W-NARROW_W){1'b0}}, raw[NARROW_W-1:0]};
    endfunction

    function automatic trs_flags_t decode_status(input logic [ELEM_W-1:0] w, input logic wide);
        trs_flags_t f;
        if (wide) begin
            f.field  = w[ELEM_W-2];
            f.vblank = w[ELEM_W-3];
            f.hflag  = w[ELEM_W-4];
        end else begin
            f.field  = w[NARROW_W-2];
            f.vblank = w[NARROW_W-3];
            f.hflag  = w[NARROW_W-4];
        end
        return f;
    endfunction

endpackage

// File: rtl/vid656_delay.sv
module vid656_delay #(
    parameter int W     = vid656_pkg::ELEM_W,
    parameter int DEPTH = vid656_pkg::LEAD_LEN
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      adv,
    input  logic [W-1:0]              din,
    output logic [DEPTH-1:0][W-1:0]   taps,
    output logic [DEPTH-1:0]          tap_vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            taps    <= '0;
            tap_vld <= '0;
        end else if (adv) begin
            taps[0]    <= din;
            tap_vld[0] <= 1'b1;
            for (int i = 1; i < DEPTH; i++) begin
                taps[i]    <= taps[i-1];
                tap_vld[i] <= tap_vld[i-1];
            end
        end
    end
endmodule

// File: rtl/vid656_trs_detect.sv
module vid656_trs_detect
    import vid656_pkg::*;
#(
    parameter int W     = ELEM_W,
    parameter int NW    = NARROW_W,
    parameter int DEPTH = LEAD_LEN
) (
    input  logic                      adv,
    input  logic                      wide,
    input  logic [W-1:0]              din,
    input  logic [DEPTH-1:0][W-1:0]   taps,
    input  logic [DEPTH-1:0]          tap_vld,
    output logic                      hit,
    output trs_flags_t                flags
);
    localparam int OLDEST = DEPTH - 1;

    logic [DEPTH-2:0] mid_zero;
    logic             lead_ones;
    logic             stat_msb;

    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_mid
        assign mid_zero[g] = (taps[g] == '0);
    end

    always_comb begin
        if (wide) begin
            lead_ones = (taps[OLDEST] == {W{1'b1}});
            stat_msb  = din[W-1];
        end else begin
            lead_ones = (taps[OLDEST][NW-1:0] == {NW{1'b1}});
            stat_msb  = din[NW-1];
        end
        hit   = adv && (&tap_vld) && lead_ones && (&mid_zero) && stat_msb;
        flags = decode_status(din, wide);
    end
endmodule

// File: rtl/vid656_line_track.sv
module vid656_line_track
    import vid656_pkg::*;
#(
    parameter int DEPTH = LEAD_LEN
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        adv,
    input  logic        hit,
    input  trs_flags_t  flags,
    input  logic        fwd,
    output line_state_t st_mid,
    output logic        is_ctl
);
    localparam int CW = $clog2(DEPTH + 1);

    line_state_t   st_q;
    line_state_t   st_d;
    logic [CW-1:0] ctl_left;

    always_comb begin
        st_mid = st_q;
        if (hit) begin
            if (flags.hflag) begin
                st_mid.hblank = 1'b1;
            end else begin
                st_mid.hblank   = 1'b0;
                st_mid.field    = flags.field;
                st_mid.vblank   = flags.vblank;
                st_mid.sol_pend = 1'b1;
            end
        end
        st_d          = st_mid;
        st_d.sol_pend = st_mid.sol_pend & ~fwd;
    end

    assign is_ctl = hit || (ctl_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= LINE_RESET;
            ctl_left <= '0;
        end else if (adv) begin
            st_q <= st_d;
            if (hit)
                ctl_left <= CW'(DEPTH);
            else if (ctl_left != '0)
                ctl_left <= ctl_left - 1'b1;
        end
    end
endmodule

// File: rtl/vid656_gate.sv
module vid656_gate
    import vid656_pkg::*;
(
    input  cap_mode_e   mode,
    input  logic        tap_ok,
    input  logic        is_ctl,
    input  line_state_t st,
    output logic        fwd
);
    always_comb begin
        unique case (mode)
            CAP_ACTIVE: fwd = tap_ok && !is_ctl && !st.hblank && !st.vblank;
            CAP_VBLANK: fwd = tap_ok && st.vblank;
            default:    fwd = tap_ok;
        endcase
    end
endmodule

// File: rtl/vid656_rx_filter.sv
module vid656_rx_filter
    import vid656_pkg::*;
#(
    parameter int W     = ELEM_W,
    parameter int NW    = NARROW_W,
    parameter int DEPTH = LEAD_LEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [W-1:0]  in_data,
    input  logic          cfg_wide,
    input  logic [1:0]    cfg_mode,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic          out_sol,
    output logic          out_field,
    output logic          out_vblank
);
    localparam int OLDEST = DEPTH - 1;

    logic [W-1:0]            din_n;
    logic [DEPTH-1:0][W-1:0] taps;
    logic [DEPTH-1:0]        tap_vld;
    logic                    hit;
    trs_flags_t              flags;
    line_state_t             st_mid;
    logic                    is_ctl;
    logic                    fwd;

    assign din_n = norm_elem(in_data, cfg_wide);

    vid656_delay #(.W(W), .DEPTH(DEPTH)) delay_i (
        .clk(clk), .rst(rst), .adv(in_valid), .din(din_n),
        .taps(taps), .tap_vld(tap_vld)
    );

    vid656_trs_detect #(.W(W), .NW(NW), .DEPTH(DEPTH)) detect_i (
        .adv(in_valid), .wide(cfg_wide), .din(din_n), .taps(taps),
        .tap_vld(tap_vld), .hit(hit), .flags(flags)
    );

    vid656_line_track #(.DEPTH(DEPTH)) track_i (
        .clk(clk), .rst(rst), .adv(in_valid), .hit(hit), .flags(flags),
        .fwd(fwd), .st_mid(st_mid), .is_ctl(is_ctl)
    );

    vid656_gate gate_i (
        .mode(cap_mode_e'(cfg_mode)), .tap_ok(in_valid && tap_vld[OLDEST]),
        .is_ctl(is_ctl), .st(st_mid), .fwd(fwd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_sol    <= 1'b0;
            out_field  <= 1'b0;
            out_vblank <= 1'b0;
        end else begin
            out_valid <= fwd;
            out_sol   <= fwd && st_mid.sol_pend;
            if (fwd) begin
                out_data   <= taps[OLDEST];
                out_field  <= st_mid.field;
                out_vblank <= st_mid.vblank;
            end
        end
    end
endmodule

// File: rtl/vid656_rx_filter_chk.sv
module vid656_rx_filter_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       cfg_wide,
    input logic [1:0] cfg_mode,
    input logic       out_valid,
    input logic [9:0] out_data,
    input logic       out_sol,
    input logic       out_vblank
);
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(cfg_wide)) |-> (out_data[9:8] == 2'b00)); // R2
    AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)); // R3
    AST_ACTIVE_NOT_VBLANK: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cfg_mode) == 2'd0) |-> !out_vblank); // R5
    AST_VBLANK_MODE_ONLY_V: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cfg_mode) == 2'd1) |-> out_vblank); // R6
    AST_SOL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> out_valid); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_sol)); // R10
endmodule

bind vid656_rx_filter vid656_rx_filter_chk chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cfg_wide(cfg_wide),
    .cfg_mode(cfg_mode), .out_valid(out_valid), .out_data(out_data),
    .out_sol(out_sol), .out_vblank(out_vblank)
);

// File: tb/vid656_rx_filter_tb.sv
module vid656_rx_filter_tb_top;

    typedef struct packed {
        logic [9:0] data;
        logic       sol;
        logic       field;
        logic       vblank;
    } exp_t;

    localparam int K_CTL = 0, K_BLANK = 1, K_ACT = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [9:0] in_data = '0;
    logic       cfg_wide = 1'b1;
    logic [1:0] cfg_mode = 2'd2;
    logic       out_valid;
    logic [9:0] out_data;
    logic       out_sol;
    logic       out_field;
    logic       out_vblank;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    bit   gaps = 1'b0;
    exp_t sb[$];

    // bench-side line model
    logic m_v, m_f, m_sp;

    always #4 clk = ~clk;

    vid656_rx_filter dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .cfg_wide(cfg_wide), .cfg_mode(cfg_mode), .out_valid(out_valid),
        .out_data(out_data), .out_sol(out_sol), .out_field(out_field),
        .out_vblank(out_vblank)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // monitor: pop and compare
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R5/R6/R7", "unexpected element", {6'd0, out_data}, 16'hFFFF);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_data == e.data, "R3/R2", "data", {6'd0, out_data}, {6'd0, e.data});
                check(out_sol == e.sol, "R8", "sol", {15'd0, out_sol}, {15'd0, e.sol});
                check({out_field, out_vblank} == {e.field, e.vblank}, "R9", "field/vblank",
                      {14'd0, out_field, out_vblank}, {14'd0, e.field, e.vblank});
            end
        end
    end

    task automatic send_elem(input logic [9:0] raw, input int kind, input bit tail);
        bit   pass;
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = raw;
        if (!tail) begin
            if (cfg_mode >= 2'd2)      pass = 1'b1;               // R7
            else if (cfg_mode == 2'd1) pass = m_v;                // R6
            else                       pass = (kind == K_ACT) && !m_v; // R5
            if (pass) begin
                e.data   = cfg_wide ? raw : {2'b00, raw[7:0]};
                e.sol    = m_sp;
                e.field  = m_f;
                e.vblank = m_v;
                m_sp     = 1'b0;
                sb.push_back(e);
            end
        end
        if (gaps) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic logic [9:0] word(input logic [7:0] b);
        return cfg_wide ? ((b == 8'hFF) ? 10'h3FF : {b, 2'b00}) : {2'b11, b};
    endfunction

    // R1: timing code
    task automatic send_trs(input logic f, input logic v, input logic h);
        logic [9:0] st;
        if (!h) begin
            m_v = v; m_f = f; m_sp = 1'b1;
        end
        st = cfg_wide ? {1'b1, f, v, h, 6'b101000} : {2'b11, 1'b1, f, v, h, 4'b0101};
        send_elem(cfg_wide ? 10'h3FF : 10'h3FF, K_CTL, 1'b0);
        send_elem(cfg_wide ? 10'h000 : 10'h300, K_CTL, 1'b0);
        send_elem(cfg_wide ? 10'h000 : 10'h300, K_CTL, 1'b0);
        send_elem(st, K_CTL, 1'b0);
    endtask

    task automatic send_line(input logic f, input logic v, input int nb, input int na);
        send_trs(f, v, 1'b1);
        for (int i = 0; i < nb; i++) send_elem(word(8'h10), K_BLANK, 1'b0);
        send_trs(f, v, 1'b0);
        for (int i = 0; i < na; i++)
            send_elem(cfg_wide ? 10'(10'h100 + i) : {2'b11, 8'(8'h40 + i)}, K_ACT, 1'b0);
    endtask

    task automatic start_test(input logic wide, input logic [1:0] mode, input bit g);
        rst = 1'b1;
        cfg_wide = wide;
        cfg_mode = mode;
        gaps = g;
        m_v = 1'b0; m_f = 1'b0; m_sp = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0 && out_sol == 1'b0, "R10", "outputs in reset",
              {15'd0, out_valid}, 16'd0);
        rst = 1'b0;
    endtask

    task automatic end_test(input string req);
        for (int i = 0; i < 3; i++) send_elem(word(8'h20), K_BLANK, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(sb.size() == 0, req, "leftover expected items", 16'(sb.size()), 16'd0);
        sb.delete();
    endtask

    initial begin
        // stale elements before reset must never appear (R10)
        rst = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = 10'h155;
        @(negedge clk);
        in_data = 10'h0AA;
        @(negedge clk);
        in_valid = 1'b0;

        // R7, R1: wide entire stream with a near-miss code
        start_test(1'b1, 2'd2, 1'b0);
        send_line(1'b0, 1'b1, 2, 2);
        send_elem(10'h0FF, K_BLANK, 1'b0);
        send_elem(10'h000, K_BLANK, 1'b0);
        send_elem(10'h000, K_BLANK, 1'b0);
        send_elem(10'h2C0, K_BLANK, 1'b0);
        send_line(1'b0, 1'b0, 2, 3);
        send_line(1'b1, 1'b0, 1, 2);
        end_test("R7");

        // R5: wide active only
        start_test(1'b1, 2'd0, 1'b0);
        send_line(1'b0, 1'b1, 2, 3);
        send_line(1'b0, 1'b0, 2, 4);
        send_line(1'b1, 1'b0, 3, 2);
        send_line(1'b1, 1'b1, 1, 2);
        end_test("R5");

        // R6: wide vblank only
        start_test(1'b1, 2'd1, 1'b0);
        send_line(1'b0, 1'b0, 2, 2);
        send_line(1'b0, 1'b1, 2, 3);
        send_line(1'b1, 1'b1, 1, 2);
        send_line(1'b1, 1'b0, 2, 2);
        end_test("R6");

        // R2, R1: narrow active only with gaps and junk upper bits
        start_test(1'b0, 2'd0, 1'b1);
        send_line(1'b1, 1'b0, 2, 4);
        send_line(1'b0, 1'b1, 1, 2);
        send_line(1'b0, 1'b0, 2, 3);
        end_test("R2");

        // R6: narrow vblank only
        start_test(1'b0, 2'd1, 1'b0);
        send_line(1'b1, 1'b1, 2, 2);
        send_line(1'b1, 1'b0, 1, 3);
        end_test("R6");

        // R4: mode 3 behaves as entire stream
        start_test(1'b0, 2'd3, 1'b0);
        send_line(1'b0, 1'b0, 1, 2);
        send_line(1'b1, 1'b1, 2, 2);
        end_test("R4");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule